// File: doc/BRIEF.md
# Seven-to-one pixel serializer

This block turns one wide parallel pixel word per pixel clock into narrow serial streams for a display link. Each pixel period it captures a 28-bit word and splits it into four 7-bit symbols. Each symbol leaves on its own data lane, one bit per bit-clock cycle, most significant bit first. A fifth lane carries a forwarded clock: four bit times high, then three low. A receiver uses the rising transition of that clock to find where each symbol starts.

The block runs from two clocks. One is the pixel clock. The other is a bit clock at seven times the pixel rate, which a PLL outside the block provides. A select input chooses which pixel-clock edge captures the input word. A narrow-colour mode parks the top lane in high impedance, because that lane is not needed at 18-bit colour depth. A low enable puts the block to sleep: every lane, the clock lane included, is driven low, and this wins over the narrow-mode tri-state. Each output is a single-ended bit with its own output-enable; these stand in for the differential drivers.

Top module: `pix_serializer`

## Requirements
- R1: Every 7 bit clocks each active data lane n sends bits [7n+6:7n] of one captured word. It sends bit 7n+6 in the same cycle that the clock lane goes high, then the lower bits in descending order, one per bit clock. Words follow each other with no gap.
- R2: While enabled, the clock lane repeats a pattern of 4 bit-clock cycles high followed by 3 bit-clock cycles low.
- R3: With `cap_rise`=1 the transferred word is the one held at the most recent rising edge of `pix_clk`. With `cap_rise`=0 it is the one held at the most recent falling edge.
- R4: With `en`=1 and `mode18`=1, lane 3 has `lane_oe[3]`=0 and `lane_data[3]`=0, and input bits 27:21 reach no output.
- R5: With `en`=1 and `mode18`=0, all four data-lane output-enables are 1.
- R6: With `en`=0, all data lanes and `lane_clk` are 0 and all output-enables are 1, whatever `mode18` is.
- R7: At the first bit-clock edge at which `en` is sampled high, a new word starts: `lane_clk` goes high and each lane shows the first bit of a freshly transferred symbol.
- R8: While `rst_n` is low, `lane_clk` and all data lanes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate, edge-aligned to the pixel clock |
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset, applied in both clock domains |
| en | input | 1 | 1 = active, 0 = sleep with all lanes driven low |
| cap_rise | input | 1 | 1 = capture on the rising pixel-clock edge, 0 = on the falling edge |
| mode18 | input | 1 | 1 = lane 3 in high impedance (18-bit colour), 0 = all lanes active |
| pix_data | input | 28 | Parallel pixel word |
| lane_data | output | 4 | Serial data, one bit per lane |
| lane_oe | output | 4 | Output-enable per data lane |
| lane_clk | output | 1 | Forwarded clock lane |
| lane_clk_oe | output | 1 | Output-enable of the clock lane (always 1) |

## Verification
Two functions can act in the same cycle. The first pair is the symbol load, which happens once every seven bit clocks, and the capture edge, which decides which word that load picks up. The bench enables the block at a point where the loads fall between a falling and the next rising pixel edge, so the two capture modes must transfer different words. The second pair is sleep and the narrow mode, which can both be requested at once. The bench holds `mode18` high while it drops `en`, and requires lane 3 to come out as a driven low, not as high impedance. Every bit on every lane is compared with a behavioural model, and the bench also rebuilds whole words from the outputs to compare them.

// File: rtl/pxs_pkg.sv
// Shared constants of the pixel serializer: lane count, symbol width and the
// forwarded clock's high-phase length. Assumes one symbol per lane per pixel.
package pxs_pkg;
    localparam int unsigned PXS_LANES   = 4;
    localparam int unsigned PXS_SYM_W   = 7;
    localparam int unsigned PXS_CLK_HI  = 4;
    localparam int unsigned PXS_WORD_W  = PXS_LANES * PXS_SYM_W;
endpackage

// File: rtl/pxs_capture.sv
// Input capture: registers the pixel word on both pixel-clock edges and
// selects one of the two copies. Assumes the data meets setup and hold at the
// chosen edge, and that the selected copy changes only away from bit-clock
// rising edges (the pixel and bit clocks are phase aligned).
module pxs_capture #(
    parameter int unsigned WORD_W = 28
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              cap_rise,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] rise_q;
    logic [WORD_W-1:0] fall_q;

    // Capture on the rising pixel edge.
    always_ff @(posedge pix_clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= din;
    end

    // Capture on the falling pixel edge.
    always_ff @(negedge pix_clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= din;
    end

    // Pick the copy that belongs to the selected edge.
    always_comb word = cap_rise ? rise_q : fall_q;
endmodule

// File: rtl/pxs_phase.sv
// Bit-phase sequencer: counts bit-clock cycles within a pixel period, emits
// the symbol-load strobe and the registered forwarded-clock level. Held at
// phase zero while not running, so the first cycle after start is a load.
module pxs_phase #(
    parameter int unsigned SYM_W = 7,
    parameter int unsigned HI_W  = 4
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic run,
    output logic load,
    output logic clk_q
);
    localparam int unsigned PH_W = $clog2(SYM_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);
    localparam logic [PH_W-1:0] PH_HI   = PH_W'(HI_W);

    logic [PH_W-1:0] ph;

    // Advance the phase and register the clock-lane level for this phase.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !run) begin
            ph    <= '0;
            clk_q <= 1'b0;
        end else begin
            ph    <= (ph == PH_LAST) ? '0 : ph + 1'b1;
            clk_q <= (ph < PH_HI);
        end
    end

    // A new symbol enters the shifters at phase zero.
    always_comb load = run && (ph == '0);
endmodule

// File: rtl/pxs_lane.sv
// One serial lane: a shift register that loads a symbol on the load strobe
// and shifts it out MSB first. Cleared while not running so that the output
// is low and the next start begins with a full symbol.
module pxs_lane #(
    parameter int unsigned SYM_W = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [SYM_W-1:0] sym,
    output logic             sout
);
    logic [SYM_W-1:0] sreg;

    // Load a fresh symbol at phase zero, otherwise shift towards the MSB.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !run) sreg <= '0;
        else if (load)      sreg <= sym;
        else                sreg <= {sreg[SYM_W-2:0], 1'b0};
    end

    // The serial bit is the register's top bit.
    always_comb sout = sreg[SYM_W-1];
endmodule

// File: rtl/pix_serializer.sv
// Seven-to-one pixel serializer top. Captures one word per pixel clock,
// sends a 7-bit slice per lane per pixel plus a 4-high/3-low forwarded clock.
// Assumes bit_clk is exactly seven times pix_clk and phase aligned with it.
// Sleep (en=0) forces every lane low and driven, overriding the narrow-mode
// tri-state of the top lane.
module pix_serializer
    import pxs_pkg::*;
#(
    parameter int unsigned LANES  = PXS_LANES,
    parameter int unsigned SYM_W  = PXS_SYM_W,
    parameter int unsigned CLK_HI = PXS_CLK_HI
) (
    input  logic                     bit_clk,
    input  logic                     pix_clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     cap_rise,
    input  logic                     mode18,
    input  logic [LANES*SYM_W-1:0]   pix_data,
    output logic [LANES-1:0]         lane_data,
    output logic [LANES-1:0]         lane_oe,
    output logic                     lane_clk,
    output logic                     lane_clk_oe
);
    localparam int unsigned WORD_W   = LANES * SYM_W;
    localparam int unsigned TRI_LANE = LANES - 1;

    logic [WORD_W-1:0] cap_word;
    logic              load;
    logic              clk_q;
    logic [LANES-1:0]  sout;

    pxs_capture #(.WORD_W(WORD_W)) u_capture (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .cap_rise (cap_rise),
        .din      (pix_data),
        .word     (cap_word)
    );

    pxs_phase #(.SYM_W(SYM_W), .HI_W(CLK_HI)) u_phase (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .run     (en),
        .load    (load),
        .clk_q   (clk_q)
    );

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            logic lane_run;
            logic lane_drv;
            if (gi == TRI_LANE) begin : g_narrowable
                // The top lane idles (and ignores its bits) in narrow mode.
                always_comb lane_run = en && !mode18;
                always_comb lane_drv = !mode18;
            end else begin : g_fixed
                // Lower lanes are always in use while enabled.
                always_comb lane_run = en;
                always_comb lane_drv = 1'b1;
            end

            pxs_lane #(.SYM_W(SYM_W)) u_lane (
                .bit_clk (bit_clk),
                .rst_n   (rst_n),
                .run     (lane_run),
                .load    (load),
                .sym     (cap_word[gi*SYM_W +: SYM_W]),
                .sout    (sout[gi])
            );

            // Sleep drives low and enabled; otherwise the lane's mode decides.
            always_comb begin
                lane_data[gi] = en && lane_drv && sout[gi];
                lane_oe[gi]   = !en || lane_drv;
            end
        end
    endgenerate

    // Clock lane is always driven; sleep forces it low.
    always_comb begin
        lane_clk    = en && clk_q;
        lane_clk_oe = 1'b1;
    end
endmodule

// File: rtl/pxs_checker.sv
// Property checker for the pixel serializer, bound to every instance of the
// top. Observes ports only.
module pxs_checker #(
    parameter int unsigned LANES = 4
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             en,
    input logic             mode18,
    input logic [LANES-1:0] lane_data,
    input logic [LANES-1:0] lane_oe,
    input logic             lane_clk
);
    AST_SLEEP_DRIVES_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !en |-> (lane_data == '0 && !lane_clk && &lane_oe)); // R6

    AST_NARROW_TRISTATE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en && mode18) |-> (!lane_oe[LANES-1] && !lane_data[LANES-1])); // R4

    AST_WIDE_ALL_ON: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en && !mode18) |-> &lane_oe); // R5

    AST_CLK_HIGH_RUN: assert property (@(posedge bit_clk) disable iff (!rst_n || !en)
        $rose(lane_clk) |=> lane_clk ##1 lane_clk ##1 lane_clk ##1 !lane_clk); // R2

    AST_CLK_LOW_RUN: assert property (@(posedge bit_clk) disable iff (!rst_n || !en)
        $fell(lane_clk) |=> !lane_clk ##1 !lane_clk ##1 lane_clk); // R2

    AST_WAKE_STARTS_HIGH: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(en) |=> (lane_clk || !en)); // R7

    AST_RESET_QUIET: assert property (@(posedge bit_clk)
        !rst_n |=> (lane_data == '0 && !lane_clk)); // R8
endmodule

bind pix_serializer pxs_checker #(.LANES(LANES)) u_pxs_checker (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode18    (mode18),
    .lane_data (lane_data),
    .lane_oe   (lane_oe),
    .lane_clk  (lane_clk)
);

// File: tb/pix_serializer_tb.sv
`timescale 1ns/1ps
module pix_serializer_tb;
    localparam int NL = 4;
    localparam int SW = 7;

    logic bit_clk = 1'b0;
    logic pix_clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic cap_rise = 1'b1;
    logic mode18 = 1'b0;
    logic [NL*SW-1:0] pix_data = '0;
    logic [NL-1:0] lane_data, lane_oe;
    logic lane_clk, lane_clk_oe;

    int checks = 0;
    int fails = 0;

    pix_serializer u_dut (
        .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n), .en(en),
        .cap_rise(cap_rise), .mode18(mode18), .pix_data(pix_data),
        .lane_data(lane_data), .lane_oe(lane_oe), .lane_clk(lane_clk),
        .lane_clk_oe(lane_clk_oe)
    );

    // 125 MHz bit clock: rising edges at 4 + 8k ns
    always #4 bit_clk = ~bit_clk;

    // Pixel clock: rises on a bit falling edge, 4 bit times high, 3 low
    initial begin
        #8;
        forever begin
            pix_clk = 1'b1; #32;
            pix_clk = 1'b0; #24;
        end
    end

    // New random pixel word each pixel, between the two pixel edges
    initial begin
        #26;
        forever begin
            pix_data = 28'($urandom);
            #56;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: words held at each pixel edge
    logic [NL*SW-1:0] m_rise = '0, m_fall = '0;
    always @(posedge pix_clk) m_rise = rst_n ? pix_data : '0;
    always @(negedge pix_clk) m_fall = rst_n ? pix_data : '0;

    int k = 0;
    bit first_cyc = 0;
    logic [NL*SW-1:0] m_word = '0;
    logic [SW-1:0] rec [NL];

    // Model each bit-clock cycle, then compare outputs mid-cycle
    always @(posedge bit_clk) begin
        bit s_rst, s_en, s_m18, s_active, s_clk, s_done, s_first;
        logic [NL-1:0] s_bit;
        s_rst = rst_n; s_en = en; s_m18 = mode18;
        s_active = 0; s_clk = 0; s_bit = '0; s_done = 0; s_first = 0;
        if (!rst_n || !en) begin
            k = 0;
            first_cyc = 1;
        end else begin
            if (k == 0) m_word = cap_rise ? m_rise : m_fall;
            s_active = 1;
            s_first = first_cyc;
            first_cyc = 0;
            s_clk = (k < 4);
            for (int l = 0; l < NL; l++) s_bit[l] = m_word[l*SW + SW-1 - k];
            k = (k + 1) % SW;
            s_done = (k == 0);
        end
        #2;
        if (!s_en) begin
            chk(lane_data == '0 && !lane_clk && lane_oe == '1 && lane_clk_oe,
                "R6 sleep drives low", {lane_oe, lane_data, lane_clk}, {4'hf, 4'h0, 1'b0});
        end else if (!s_rst) begin
            chk(lane_data == '0 && !lane_clk, "R8 reset outputs low",
                {lane_data, lane_clk}, 0);
        end else if (s_active) begin
            chk(lane_clk == s_clk, "R2 clock lane pattern", lane_clk, s_clk);
            if (s_first) chk(lane_clk == 1'b1, "R7 wake starts new word", lane_clk, 1);
            for (int l = 0; l < NL-1; l++) begin
                chk(lane_data[l] == s_bit[l], "R1 lane bit", lane_data[l], s_bit[l]);
                rec[l] = {rec[l][SW-2:0], lane_data[l]};
            end
            if (s_m18) begin
                chk(!lane_oe[NL-1] && !lane_data[NL-1], "R4 top lane tri-state",
                    {lane_oe[NL-1], lane_data[NL-1]}, 0);
            end else begin
                chk(lane_oe == '1, "R5 all lanes enabled", lane_oe, 4'hf);
                chk(lane_data[NL-1] == s_bit[NL-1], "R1 top lane bit",
                    lane_data[NL-1], s_bit[NL-1]);
            end
            rec[NL-1] = {rec[NL-1][SW-2:0], lane_data[NL-1]};
            if (s_done) begin
                logic [NL*SW-1:0] got, want;
                for (int l = 0; l < NL; l++) got[l*SW +: SW] = rec[l];
                want = m_word;
                if (s_m18) begin
                    got[NL*SW-1 -: SW] = '0;
                    want[NL*SW-1 -: SW] = '0;
                end
                chk(got == want, cap_rise ? "R3 recovered word (rising capture)"
                                          : "R3 recovered word (falling capture)",
                    32'(got), 32'(want));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge bit_clk);
        #1;
    endtask

    // Raise en so that symbol loads fall between a falling and a rising pixel edge
    task automatic wake_aligned();
        @(posedge pix_clk);
        #41;
        en = 1'b1;
    endtask

    initial begin
        // Reset with en high: outputs must stay quiet (R8)
        tick(12);
        rst_n = 1'b1;
        tick(30);
        en = 1'b0;
        tick(10);

        // Rising capture, wide mode
        cap_rise = 1'b1; mode18 = 1'b0;
        wake_aligned();
        tick(40*SW);
        en = 1'b0;
        tick(15);

        // Falling capture, wide mode
        cap_rise = 1'b0;
        wake_aligned();
        tick(40*SW);
        en = 1'b0;
        tick(10);

        // Narrow mode, then sleep while narrow mode is still requested
        mode18 = 1'b1;
        wake_aligned();
        tick(30*SW);
        en = 1'b0;
        tick(20);

        // Narrow mode with rising capture, unaligned wake-up
        cap_rise = 1'b1;
        tick(3);
        en = 1'b1;
        tick(20*SW + 3);
        en = 1'b0;
        tick(10);

        // Back to wide mode, unaligned wake-up
        mode18 = 1'b0;
        tick(5);
        en = 1'b1;
        tick(20*SW);
        en = 1'b0;
        tick(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule